// File: doc/BRIEF.md
# Counted Vector Mode Sequencer

This control unit lets a scalar core run a short burst of instructions in a vector mode. An entry command selects a vector width, a lane element size, an optional per-lane predicate mask and a 3-bit instruction count. The sequencer then holds the core in vector mode while that many instructions retire, and drops back to scalar mode on its own when the count runs out. The decoder and execute stage see the current mode, width and lane size, and a per-lane enable vector built from the lane count and the predicate.

Interrupts always take the core to scalar mode. The remaining count and the rest of the mode settings are kept in a readable mode-state word, so that a handler can save them, reuse vector mode itself, write them back and resume the interrupted window with a restore command. The mode-state word and the predicate mask can be read and written at any time, with no privilege check.

Top module: `vmode_seq`

## Requirements
- R1: After reset the block is in scalar mode, every mode field and the mask read as zero, and `lane_en` is zero.
- R2: An entry command stores width (00=32, 01=64, 10=128, 11=256 bits), lane size (00=byte, 01=16-bit, 10=32-bit; code 11 is stored as 10), predicate enable and count. Vector mode is active from the next cycle only if the count is nonzero.
- R3: While vector mode is active, each `retire` pulse lowers the count by one, and a cycle without `retire` leaves it unchanged. The edge that takes the count from 1 to 0 also returns the block to scalar mode. In scalar mode `retire` changes nothing. A `retire` in the same cycle as an entry, restore or register write is not counted.
- R4: An entry command with predicate enable set loads `enter_mask` into the mask. With predicate enable clear, the mask keeps its previous value.
- R5: In vector mode, bit i of `lane_en` is 1 when i < 2^(width code + 2 − lane code) and, if predication is on, mask bit i is 1. In scalar mode `lane_en` is all zero.
- R6: An entry command issued during active vector mode replaces the width, lane size, predicate and count at the next edge.
- R7: `irq_take` forces scalar mode at the next edge and keeps all fields. A `retire` in the same cycle is still counted. Restore, writes and entry issued in that cycle are ignored.
- R8: `state_rdata` packs count in bits [2:0], width code in [4:3], lane code in [6:5] and predicate enable in bit 7. All higher bits read 0. `mask_rdata` returns the mask.
- R9: `state_wr` loads the fields from the same bit positions of `state_wdata` (lane code 11 stored as 10) and leaves the block in scalar mode. `mask_wr` loads the mask and does not change the mode.
- R10: `restore` re-enters vector mode at the next edge when the stored count is nonzero, and then stays there for exactly that many retires. With a zero count it stays scalar.
- R11: Priority is `irq_take`, then `restore`, then the register writes, then entry. A lower-priority command issued in the same cycle as a higher one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enter_valid | input | 1 | Mode-entry command |
| enter_width | input | 2 | Width code for entry |
| enter_lane | input | 2 | Lane size code for entry |
| enter_pred | input | 1 | Predication enable for entry |
| enter_count | input | 3 | Number of instructions to run in vector mode |
| enter_mask | input | 32 | Register value taken as predicate mask |
| retire | input | 1 | One instruction retired this cycle |
| irq_take | input | 1 | Interrupt entry |
| restore | input | 1 | Restore command |
| state_wr | input | 1 | Write the mode-state word |
| state_wdata | input | 32 | Mode-state word to write |
| mask_wr | input | 1 | Write the predicate mask |
| mask_wdata | input | 32 | Predicate mask to write |
| vec_active | output | 1 | Vector mode active |
| vec_width | output | 2 | Current width code |
| vec_lane | output | 2 | Current lane size code |
| vec_pred | output | 1 | Current predicate enable |
| lane_en | output | 32 | Per-lane enables for execute |
| state_rdata | output | 32 | Packed mode-state word |
| mask_rdata | output | 32 | Predicate mask |

## Verification
The hardest case to reach is the resume path. The bench has to open a window, let part of it retire, take an interrupt, overwrite the settings with a nested window and write the saved word back. It then restores, and the window must finish after exactly the saved number of retires. A directed sequence walks this path, including an interrupt that lands on a retire edge. Random cycles then raise every command strobe on its own so that commands often collide in one cycle, and each collision is checked against the priority order.

// File: rtl/vmode_pkg.sv
package vmode_pkg;

    typedef enum logic [1:0] {
        WID_32  = 2'b00,
        WID_64  = 2'b01,
        WID_128 = 2'b10,
        WID_256 = 2'b11
    } width_code_e;

    typedef enum logic [1:0] {
        LN_BYTE = 2'b00,
        LN_HALF = 2'b01,
        LN_FULL = 2'b10,
        LN_RSVD = 2'b11
    } lane_code_e;

    // The reserved lane code behaves as the widest lane.
    function automatic logic [1:0] lane_fix(input logic [1:0] code);
        return (code == LN_RSVD) ? LN_FULL : code;
    endfunction

endpackage

// File: rtl/vmode_word.sv
module vmode_word #(
    parameter int CNT_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [CNT_W-1:0]  cur_count,
    input  logic [1:0]        cur_width,
    input  logic [1:0]        cur_lane,
    input  logic              cur_pred,
    output logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] wr_word,
    output logic [CNT_W-1:0]  wr_count,
    output logic [1:0]        wr_width,
    output logic [1:0]        wr_lane,
    output logic              wr_pred
);
    import vmode_pkg::*;

    localparam int WID_LSB  = CNT_W;
    localparam int LANE_LSB = CNT_W + 2;
    localparam int PRED_BIT = CNT_W + 4;
    localparam int FIELD_W  = CNT_W + 5;

    always_comb begin
        rd_word = '0;
        rd_word[FIELD_W-1:0] = {cur_pred, cur_lane, cur_width, cur_count};
    end

    always_comb begin
        wr_count = wr_word[CNT_W-1:0];
        wr_width = wr_word[WID_LSB +: 2];
        wr_lane  = lane_fix(wr_word[LANE_LSB +: 2]);
        wr_pred  = wr_word[PRED_BIT];
    end

endmodule

// File: rtl/vmode_lane_gate.sv
module vmode_lane_gate #(
    parameter int MASK_W = 32
) (
    input  logic              active,
    input  logic [1:0]        width,
    input  logic [1:0]        lane,
    input  logic              pred,
    input  logic [MASK_W-1:0] mask,
    output logic [MASK_W-1:0] lane_en
);
    localparam int LC_W = $clog2(MASK_W) + 1;

    logic [2:0]      shift;
    logic [LC_W-1:0] n_lanes;

    always_comb begin
        shift   = 3'(width) + 3'd2 - 3'(lane);
        n_lanes = LC_W'(1) << shift;
    end

    for (genvar i = 0; i < MASK_W; i++) begin : g_lane
        localparam logic [LC_W-1:0] IDX = LC_W'(i);
        assign lane_en[i] = active & (IDX < n_lanes) & (~pred | mask[i]);
    end

endmodule

// File: rtl/vmode_seq.sv
module vmode_seq #(
    parameter int CNT_W  = 3,
    parameter int MASK_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_valid,
    input  logic [1:0]        enter_width,
    input  logic [1:0]        enter_lane,
    input  logic              enter_pred,
    input  logic [CNT_W-1:0]  enter_count,
    input  logic [MASK_W-1:0] enter_mask,
    input  logic              retire,
    input  logic              irq_take,
    input  logic              restore,
    input  logic              state_wr,
    input  logic [DATA_W-1:0] state_wdata,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    output logic              vec_active,
    output logic [1:0]        vec_width,
    output logic [1:0]        vec_lane,
    output logic              vec_pred,
    output logic [MASK_W-1:0] lane_en,
    output logic [DATA_W-1:0] state_rdata,
    output logic [MASK_W-1:0] mask_rdata
);
    import vmode_pkg::*;

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              active;
        logic [1:0]        width;
        logic [1:0]        lane;
        logic              pred;
        logic [CNT_W-1:0]  count;
        logic [MASK_W-1:0] mask;
    } seq_state_t;

    seq_state_t state_d, state_q;

    logic [CNT_W-1:0] wr_count;
    logic [1:0]       wr_width;
    logic [1:0]       wr_lane;
    logic             wr_pred;

    vmode_word #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_word (
        .cur_count (state_q.count),
        .cur_width (state_q.width),
        .cur_lane  (state_q.lane),
        .cur_pred  (state_q.pred),
        .rd_word   (state_rdata),
        .wr_word   (state_wdata),
        .wr_count  (wr_count),
        .wr_width  (wr_width),
        .wr_lane   (wr_lane),
        .wr_pred   (wr_pred)
    );

    // Next state, highest priority first: interrupt, restore, writes, entry, retire.
    always_comb begin
        state_d = state_q;
        if (irq_take) begin
            if (state_q.active && retire) begin
                state_d.count = state_q.count - CNT_ONE;
            end
            state_d.active = 1'b0;
        end else if (restore) begin
            state_d.active = (state_q.count != '0);
        end else if (state_wr || mask_wr) begin
            if (state_wr) begin
                state_d.count  = wr_count;
                state_d.width  = wr_width;
                state_d.lane   = wr_lane;
                state_d.pred   = wr_pred;
                state_d.active = 1'b0;
            end
            if (mask_wr) begin
                state_d.mask = mask_wdata;
            end
        end else if (enter_valid) begin
            state_d.width  = enter_width;
            state_d.lane   = lane_fix(enter_lane);
            state_d.pred   = enter_pred;
            state_d.count  = enter_count;
            state_d.active = (enter_count != '0);
            if (enter_pred) begin
                state_d.mask = enter_mask;
            end
        end else if (retire && state_q.active) begin
            state_d.count  = state_q.count - CNT_ONE;
            state_d.active = (state_q.count != CNT_ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    vmode_lane_gate #(.MASK_W(MASK_W)) u_gate (
        .active  (state_q.active),
        .width   (state_q.width),
        .lane    (state_q.lane),
        .pred    (state_q.pred),
        .mask    (state_q.mask),
        .lane_en (lane_en)
    );

    assign vec_active = state_q.active;
    assign vec_width  = state_q.width;
    assign vec_lane   = state_q.lane;
    assign vec_pred   = state_q.pred;
    assign mask_rdata = state_q.mask;

endmodule

// File: rtl/vmode_seq_chk.sv
module vmode_seq_chk #(
    parameter int CNT_W  = 3,
    parameter int MASK_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enter_valid,
    input logic              retire,
    input logic              irq_take,
    input logic              restore,
    input logic              state_wr,
    input logic              mask_wr,
    input logic              vec_active,
    input logic [MASK_W-1:0] lane_en,
    input logic [DATA_W-1:0] state_rdata
);
    localparam int FIELD_W = CNT_W + 5;

    logic any_cmd;
    assign any_cmd = enter_valid | restore | state_wr | mask_wr | irq_take;

    // R3: a counted retire lowers the count by one
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_active && retire && !any_cmd) |=>
        (state_rdata[CNT_W-1:0] == $past(state_rdata[CNT_W-1:0]) - CNT_W'(1)));

    // R3: vector mode never shows an exhausted count
    p_active_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_active |-> (state_rdata[CNT_W-1:0] != '0));

    // R3: quiet scalar cycles change nothing
    p_scalar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_active && !any_cmd) |=> (!vec_active && $stable(state_rdata)));

    // R5: no lane enabled in scalar mode
    p_lane_scalar_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_active |-> (lane_en == '0));

    // R7: interrupt forces scalar mode
    p_irq_scalar_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !vec_active);

    // R8: unused word bits read zero
    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        state_rdata[DATA_W-1:FIELD_W] == '0);

    // R2: the reserved lane code is never held
    p_lane_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_rdata[CNT_W+2 +: 2] != 2'b11);

    // R10: restore activates exactly when the count is nonzero
    p_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !irq_take) |=> (vec_active == (state_rdata[CNT_W-1:0] != '0)));

endmodule

bind vmode_seq vmode_seq_chk #(.CNT_W(CNT_W), .MASK_W(MASK_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enter_valid (enter_valid),
    .retire      (retire),
    .irq_take    (irq_take),
    .restore     (restore),
    .state_wr    (state_wr),
    .mask_wr     (mask_wr),
    .vec_active  (vec_active),
    .lane_en     (lane_en),
    .state_rdata (state_rdata)
);

// File: tb/vmode_seq_bench.sv
`timescale 1ns/1ps
module vmode_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enter_valid = 0, enter_pred = 0, retire = 0, irq_take = 0;
    logic        restore = 0, state_wr = 0, mask_wr = 0;
    logic [1:0]  enter_width = 0, enter_lane = 0;
    logic [2:0]  enter_count = 0;
    logic [31:0] enter_mask = 0, state_wdata = 0, mask_wdata = 0;
    logic        vec_active, vec_pred;
    logic [1:0]  vec_width, vec_lane;
    logic [31:0] lane_en, state_rdata, mask_rdata;

    always #4 clk = ~clk;

    vmode_seq u_vmode_seq (
        .clk(clk), .rst_n(rst_n), .enter_valid(enter_valid), .enter_width(enter_width),
        .enter_lane(enter_lane), .enter_pred(enter_pred), .enter_count(enter_count),
        .enter_mask(enter_mask), .retire(retire), .irq_take(irq_take), .restore(restore),
        .state_wr(state_wr), .state_wdata(state_wdata), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .vec_active(vec_active), .vec_width(vec_width),
        .vec_lane(vec_lane), .vec_pred(vec_pred), .lane_en(lane_en),
        .state_rdata(state_rdata), .mask_rdata(mask_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // expected state
    bit         m_act;
    bit [1:0]   m_w, m_l;
    bit         m_p;
    bit [2:0]   m_c;
    bit [31:0]  m_mask;

    function automatic bit [1:0] fix_l(input bit [1:0] l);
        return (l == 2'b11) ? 2'b10 : l;
    endfunction

    function automatic bit [31:0] exp_lanes();
        bit [31:0] r = '0;
        int n;
        if (!m_act) return '0;
        n = 1 << (int'(m_w) + 2 - int'(m_l));
        for (int i = 0; i < 32; i++)
            r[i] = (i < n) && (!m_p || m_mask[i]);
        return r;
    endfunction

    function automatic bit [31:0] exp_word();
        return {24'b0, m_p, m_l, m_w, m_c};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "active", {31'b0, vec_active}, {31'b0, m_act});
        chk(req, "state word", state_rdata, exp_word());
        chk(req, "mask", mask_rdata, m_mask);
        chk(req, "lane_en", lane_en, exp_lanes());
        chk(req, "width", {30'b0, vec_width}, {30'b0, m_w});
        chk(req, "lane", {30'b0, vec_lane}, {30'b0, m_l});
        chk(req, "pred", {31'b0, vec_pred}, {31'b0, m_p});
    endtask

    // One clock: model the edge from the driven inputs, then compare at the falling edge.
    task automatic tick(input string req);
        bit n_act = m_act; bit [1:0] n_w = m_w, n_l = m_l; bit n_p = m_p;
        bit [2:0] n_c = m_c; bit [31:0] n_mask = m_mask;
        if (irq_take) begin
            if (m_act && retire) n_c = m_c - 3'd1;
            n_act = 0;
        end else if (restore) begin
            n_act = (m_c != 0);
        end else if (state_wr || mask_wr) begin
            if (state_wr) begin
                n_c = state_wdata[2:0]; n_w = state_wdata[4:3];
                n_l = fix_l(state_wdata[6:5]); n_p = state_wdata[7]; n_act = 0;
            end
            if (mask_wr) n_mask = mask_wdata;
        end else if (enter_valid) begin
            n_w = enter_width; n_l = fix_l(enter_lane); n_p = enter_pred;
            n_c = enter_count; n_act = (enter_count != 0);
            if (enter_pred) n_mask = enter_mask;
        end else if (retire && m_act) begin
            n_c = m_c - 3'd1; n_act = (m_c != 3'd1);
        end
        @(posedge clk);
        @(negedge clk);
        m_act = n_act; m_w = n_w; m_l = n_l; m_p = n_p; m_c = n_c; m_mask = n_mask;
        check_all(req);
    endtask

    task automatic idle();
        enter_valid = 0; retire = 0; irq_take = 0; restore = 0; state_wr = 0; mask_wr = 0;
    endtask

    task automatic do_enter(input bit [1:0] w, input bit [1:0] l, input bit p,
                            input bit [2:0] c, input bit [31:0] mk, input string req);
        idle();
        enter_valid = 1; enter_width = w; enter_lane = l; enter_pred = p;
        enter_count = c; enter_mask = mk;
        tick(req);
        idle();
    endtask

    task automatic do_retire(input string req);
        idle(); retire = 1; tick(req); idle();
    endtask

    bit [31:0] saved_word, saved_mask;

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        m_act = 0; m_w = 0; m_l = 0; m_p = 0; m_c = 0; m_mask = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 / R5: full width, byte lanes, no predicate
        do_enter(2'b11, 2'b00, 0, 3'd3, 32'h0, "R2");
        idle(); tick("R3 stall");
        do_retire("R3");
        do_retire("R3");
        do_retire("R3 last");
        chk("R3", "scalar after window", {31'b0, vec_active}, 32'd0);
        do_retire("R3 scalar retire");

        // R4: predicated entry loads the mask, unpredicated keeps it
        do_enter(2'b10, 2'b01, 1, 3'd2, 32'h0000_A5C3, "R4");
        do_enter(2'b01, 2'b00, 0, 3'd1, 32'hFFFF_FFFF, "R4 keep");
        chk("R4", "mask kept", mask_rdata, 32'h0000_A5C3);

        // R2: zero count stays scalar, reserved lane code
        do_enter(2'b00, 2'b11, 0, 3'd0, 32'h0, "R2 zero count");
        chk("R2", "lane 11 stored as 10", {30'b0, vec_lane}, 32'd2);

        // R6: entry replaces an active window
        do_enter(2'b11, 2'b10, 0, 3'd7, 32'h0, "R6");
        do_retire("R6");
        do_enter(2'b01, 2'b00, 1, 3'd2, 32'h0000_00F0, "R6 replace");
        chk("R6", "count replaced", {29'b0, state_rdata[2:0]}, 32'd2);

        // R7 / R9 / R10: interrupt mid-window, nested use, save/restore
        do_enter(2'b10, 2'b00, 1, 3'd5, 32'h1234_5678, "R7");
        do_retire("R7");
        idle(); irq_take = 1; retire = 1; restore = 1; enter_valid = 1; tick("R7 irq+retire"); idle();
        chk("R7", "count kept", {29'b0, state_rdata[2:0]}, 32'd3);
        saved_word = state_rdata; saved_mask = mask_rdata;
        do_enter(2'b00, 2'b00, 1, 3'd1, 32'h0000_000F, "R7 nested");
        do_retire("R7 nested");
        idle(); state_wr = 1; state_wdata = saved_word; mask_wr = 1; mask_wdata = saved_mask;
        retire = 1; tick("R9 write back"); idle();
        idle(); restore = 1; state_wr = 1; state_wdata = 32'h0; tick("R11 restore beats write"); idle();
        chk("R10", "resumed", {31'b0, vec_active}, 32'd1);
        do_retire("R10"); do_retire("R10"); do_retire("R10 end");
        chk("R10", "window closed", {31'b0, vec_active}, 32'd0);
        idle(); restore = 1; tick("R10 zero count"); idle();

        // R9: state write with reserved lane, mask write keeps mode
        idle(); state_wr = 1; state_wdata = 32'hFFFF_FF6A; tick("R9"); idle();
        do_enter(2'b11, 2'b00, 1, 3'd4, 32'h0, "R9 setup");
        idle(); mask_wr = 1; mask_wdata = 32'hF0F0_F0F0; retire = 1; tick("R9 mask write"); idle();
        chk("R9", "mode kept", {31'b0, vec_active}, 32'd1);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            idle();
            irq_take    = ($urandom % 100) < 4;
            restore     = ($urandom % 100) < 6;
            state_wr    = ($urandom % 100) < 4;
            mask_wr     = ($urandom % 100) < 4;
            enter_valid = ($urandom % 100) < 12;
            retire      = ($urandom % 100) < 60;
            enter_width = 2'($urandom); enter_lane = 2'($urandom);
            enter_pred  = 1'($urandom); enter_count = 3'($urandom);
            enter_mask  = $urandom; mask_wdata = $urandom; state_wdata = $urandom;
            tick("R11 random");
        end
        idle();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule